// File: doc/BRIEF.md
# Lane-Masked Three-Port RAM with Optional Read Forwarding

This block holds `DEPTH` rows of `DATA_W` bits and serves three accesses in every cycle of one clock. A write port stores data into one row, and each bit of its lane mask covers one `GRAN`-bit slice of the word. A registered read port returns a row one cycle after it is addressed. A combinational read port shows the addressed row within the same cycle.

The build-time switch `TRANSPARENT` controls what the registered port returns when it reads the row that is being written in the same cycle. With the switch set, the lanes being written are forwarded into the read result. Without it, the port returns the contents the row held before the write. On reset every row loads from a packed list of `INIT_CNT` words, and rows past the end of the list load zero. Elaboration stops with an error if `GRAN` does not evenly divide `DATA_W` or if the list is longer than the array.

Top module: `tri_port_ram`

## Requirements
- R1: For each lane `l` with `wr_lane_en[l]` high, the write stores bits `[l*GRAN +: GRAN]` of `wr_data` into row `wr_addr` at the next rising clock edge. Lanes whose mask bit is low keep their old contents.
- R2: `ra_data` combinationally shows the current contents of row `ra_addr`, including any write that landed at the most recent edge.
- R3: When `rs_en` is high at an edge, `rs_data` holds the contents of row `rs_addr` as sampled at that edge, so the data appears one cycle after the address.
- R4: With `TRANSPARENT=1`, a registered read of the row written in the same cycle returns the new data in the enabled lanes and the old contents in the other lanes.
- R5: With `TRANSPARENT=0`, a registered read of the row written in the same cycle returns the contents the row held before the write.
- R6: While `rs_en` is low, `rs_data` keeps its previous value whatever `rs_addr` does.
- R7: After reset, row `i` holds word `i` of `INIT_WORDS` (word `i` is bits `[i*DATA_W +: DATA_W]`) for `i < INIT_CNT`, and every other row holds zero.
- R8: An address of `DEPTH` or more writes nothing and reads as zero on both read ports.
- R9: While `rst_n` is low, `rs_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all ports |
| rst_n | input | 1 | Asynchronous active-low reset; loads the initial contents |
| wr_addr | input | ADDR_W | Row to write |
| wr_lane_en | input | DATA_W/GRAN | Write enable, one bit per lane |
| wr_data | input | DATA_W | Write data |
| rs_addr | input | ADDR_W | Registered read row |
| rs_en | input | 1 | Registered read enable; tie high for an always-on read |
| rs_data | output | DATA_W | Registered read data |
| ra_addr | input | ADDR_W | Combinational read row |
| ra_data | output | DATA_W | Combinational read data |

## Verification
A write and a registered read can target the same row in the same cycle. This is where the two build variants differ. The bench drives one stimulus stream into a forwarding instance and a non-forwarding instance side by side, and issues same-row write and read pairs with both full and partial lane masks. It expects merged data from the first instance and the prior row contents from the second. The combinational port reads the same row one cycle later to confirm that the write itself was stored.

// File: rtl/tri_port_ram_pkg.sv
package tri_port_ram_pkg;

  // Address width for a given row count; never narrower than one bit.
  function automatic int unsigned row_addr_bits(input int unsigned depth);
    return (depth <= 1) ? 1 : $clog2(depth);
  endfunction

  // Number of lanes, guarded so a bad granularity still elaborates far
  // enough to reach the explicit check in the top module.
  function automatic int unsigned lane_count(input int unsigned width,
                                             input int unsigned gran);
    return (gran == 0) ? 1 : width / gran;
  endfunction

endpackage

// File: rtl/tpr_store.sv
module tpr_store
  import tri_port_ram_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned DEPTH    = 12,
  parameter int unsigned GRAN     = 8,
  parameter int unsigned INIT_CNT = 4,
  parameter logic [INIT_CNT*DATA_W-1:0] INIT_WORDS = '0,
  localparam int unsigned ADDR_W = row_addr_bits(DEPTH),
  localparam int unsigned LANES  = lane_count(DATA_W, GRAN)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [LANES-1:0]              wr_lane_en,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [DEPTH-1:0][DATA_W-1:0]  rows
);

  // Zero-extending the list gives zero to every row past its end.
  localparam logic [DEPTH*DATA_W-1:0] INIT_FULL = (DEPTH*DATA_W)'(INIT_WORDS);

  logic [DEPTH-1:0] row_hit;

  always_comb begin
    for (int r = 0; r < DEPTH; r++) begin
      row_hit[r] = (wr_addr == ADDR_W'(r));
    end
  end

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam logic [GRAN-1:0] RST_V = INIT_FULL[r*DATA_W + l*GRAN +: GRAN];
      logic            lane_we;
      logic [GRAN-1:0] lane_q;

      assign lane_we = row_hit[r] & wr_lane_en[l];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lane_q <= RST_V;
        end else if (lane_we) begin
          lane_q <= wr_data[l*GRAN +: GRAN];
        end
      end

      assign rows[r][l*GRAN +: GRAN] = lane_q;
    end
  end

endmodule

// File: rtl/tpr_async_port.sv
module tpr_async_port
  import tri_port_ram_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 12,
  localparam int unsigned ADDR_W = row_addr_bits(DEPTH)
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] rows,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data
);

  // A row that matches no address leaves the output at zero.
  always_comb begin
    rd_data = '0;
    for (int r = 0; r < DEPTH; r++) begin
      if (rd_addr == ADDR_W'(r)) begin
        rd_data = rows[r];
      end
    end
  end

endmodule

// File: rtl/tpr_sync_port.sv
module tpr_sync_port
  import tri_port_ram_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned DEPTH       = 12,
  parameter int unsigned GRAN        = 8,
  parameter bit          TRANSPARENT = 1'b1,
  localparam int unsigned ADDR_W = row_addr_bits(DEPTH),
  localparam int unsigned LANES  = lane_count(DATA_W, GRAN)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DEPTH-1:0][DATA_W-1:0] rows,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [LANES-1:0]             wr_lane_en,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W-1:0]            rd_data
);

  logic [DATA_W-1:0] row_sel;
  logic              rd_in_range;
  logic [DATA_W-1:0] rd_nxt;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    row_sel     = '0;
    rd_in_range = 1'b0;
    for (int r = 0; r < DEPTH; r++) begin
      if (rd_addr == ADDR_W'(r)) begin
        row_sel     = rows[r];
        rd_in_range = 1'b1;
      end
    end
  end

  if (TRANSPARENT) begin : g_fwd
    logic same_row;
    assign same_row = rd_in_range && (wr_addr == rd_addr);

    always_comb begin
      rd_nxt = row_sel;
      for (int l = 0; l < LANES; l++) begin
        if (same_row && wr_lane_en[l]) begin
          rd_nxt[l*GRAN +: GRAN] = wr_data[l*GRAN +: GRAN];
        end
      end
    end
  end else begin : g_nofwd
    logic unused_wr;
    assign unused_wr = ^{wr_addr, wr_lane_en, wr_data, rd_in_range};
    assign rd_nxt    = row_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_nxt;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/tri_port_ram.sv
module tri_port_ram
  import tri_port_ram_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned DEPTH       = 12,
  parameter int unsigned GRAN        = 8,
  parameter bit          TRANSPARENT = 1'b1,
  parameter int unsigned INIT_CNT    = 4,
  parameter logic [INIT_CNT*DATA_W-1:0] INIT_WORDS =
    {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111},
  localparam int unsigned ADDR_W = row_addr_bits(DEPTH),
  localparam int unsigned LANES  = lane_count(DATA_W, GRAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_lane_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rs_addr,
  input  logic              rs_en,
  output logic [DATA_W-1:0] rs_data,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data
);

  localparam bit GRAN_BAD = (GRAN == 0) ? 1'b1 : ((DATA_W % GRAN) != 0);

  if (GRAN_BAD) begin : g_bad_gran
    $error("tri_port_ram: GRAN must be positive and divide DATA_W");
  end
  if (INIT_CNT > DEPTH) begin : g_bad_init
    $error("tri_port_ram: INIT_CNT exceeds DEPTH");
  end

  logic [DEPTH-1:0][DATA_W-1:0] rows;

  tpr_store #(
    .DATA_W     (DATA_W),
    .DEPTH      (DEPTH),
    .GRAN       (GRAN),
    .INIT_CNT   (INIT_CNT),
    .INIT_WORDS (INIT_WORDS)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_addr    (wr_addr),
    .wr_lane_en (wr_lane_en),
    .wr_data    (wr_data),
    .rows       (rows)
  );

  tpr_sync_port #(
    .DATA_W      (DATA_W),
    .DEPTH       (DEPTH),
    .GRAN        (GRAN),
    .TRANSPARENT (TRANSPARENT)
  ) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rows       (rows),
    .rd_addr    (rs_addr),
    .rd_en      (rs_en),
    .wr_addr    (wr_addr),
    .wr_lane_en (wr_lane_en),
    .wr_data    (wr_data),
    .rd_data    (rs_data)
  );

  tpr_async_port #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_async (
    .rows    (rows),
    .rd_addr (ra_addr),
    .rd_data (ra_data)
  );

endmodule

// File: rtl/tri_port_ram_chk.sv
module tri_port_ram_chk
  import tri_port_ram_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned DEPTH       = 12,
  parameter int unsigned GRAN        = 8,
  parameter bit          TRANSPARENT = 1'b1,
  localparam int unsigned ADDR_W = row_addr_bits(DEPTH),
  localparam int unsigned LANES  = lane_count(DATA_W, GRAN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [LANES-1:0]  wr_lane_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rs_addr,
  input logic              rs_en,
  input logic [DATA_W-1:0] rs_data,
  input logic [ADDR_W-1:0] ra_addr,
  input logic [DATA_W-1:0] ra_data
);

  AST_ASYNC_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(ra_addr) >= DEPTH) |-> (ra_data == '0));  // R8

  AST_SYNC_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_en && 32'(rs_addr) >= DEPTH) |=> (rs_data == '0));  // R8

  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_en |=> $stable(rs_data));  // R6

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(wr_addr) < DEPTH && (&wr_lane_en))
      |=> (ra_addr != $past(wr_addr) || ra_data == $past(wr_data)));  // R1

  if (TRANSPARENT) begin : g_fwd_chk
    AST_FORWARD_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_en && (&wr_lane_en) && wr_addr == rs_addr && 32'(wr_addr) < DEPTH)
        |=> (rs_data == $past(wr_data)));  // R4
  end else begin : g_old_chk
    AST_READ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_en && rs_addr == ra_addr) |=> (rs_data == $past(ra_data)));  // R5
  end

endmodule

bind tri_port_ram tri_port_ram_chk #(
  .DATA_W      (DATA_W),
  .DEPTH       (DEPTH),
  .GRAN        (GRAN),
  .TRANSPARENT (TRANSPARENT)
) u_chk (.*);

// File: tb/tri_port_ram_test.sv
module tri_port_ram_test;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 12;
  localparam int GRAN   = 8;
  localparam int LANES  = DATA_W / GRAN;
  localparam int ADDR_W = 4;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] wr_addr;
  logic [LANES-1:0]  wr_lane_en;
  logic [DATA_W-1:0] wr_data;
  logic [ADDR_W-1:0] rs_addr;
  logic              rs_en;
  logic [ADDR_W-1:0] ra_addr;
  logic [DATA_W-1:0] rs_data_t, ra_data_t, rs_data_n, ra_data_n;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [DATA_W-1:0] model [DEPTH];
  logic [DATA_W-1:0] exp_t, exp_n;
  logic [DATA_W-1:0] q_t[$];
  logic [DATA_W-1:0] q_n[$];
  string             q_tt[$];
  string             q_tn[$];

  tri_port_ram #(.TRANSPARENT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_lane_en(wr_lane_en),
    .wr_data(wr_data), .rs_addr(rs_addr), .rs_en(rs_en), .rs_data(rs_data_t),
    .ra_addr(ra_addr), .ra_data(ra_data_t));

  tri_port_ram #(.TRANSPARENT(1'b0)) uut_nt (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_lane_en(wr_lane_en),
    .wr_data(wr_data), .rs_addr(rs_addr), .rs_en(rs_en), .rs_data(rs_data_n),
    .ra_addr(ra_addr), .ra_data(ra_data_n));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, checks the combinational port,
  // queues the registered-port expectations, then updates the model.
  task automatic drive(input logic [ADDR_W-1:0] wa, input logic [LANES-1:0] wl,
                       input logic [DATA_W-1:0] wd, input logic [ADDR_W-1:0] sa,
                       input logic se, input logic [ADDR_W-1:0] aa,
                       input string ta, input string tt, input string tn);
    logic [DATA_W-1:0] ea;
    logic [DATA_W-1:0] row;
    @(negedge clk);
    wr_addr = wa; wr_lane_en = wl; wr_data = wd;
    rs_addr = sa; rs_en = se; ra_addr = aa;
    #1;
    ea = (int'(aa) < DEPTH) ? model[aa] : '0;
    check(ta, ra_data_t, ea);
    check(ta, ra_data_n, ea);
    if (se) begin
      row   = (int'(sa) < DEPTH) ? model[sa] : '0;
      exp_n = row;
      exp_t = row;
      if (wa == sa && int'(wa) < DEPTH) begin
        for (int l = 0; l < LANES; l++)
          if (wl[l]) exp_t[l*GRAN +: GRAN] = wd[l*GRAN +: GRAN];
      end
    end
    q_t.push_back(exp_t); q_n.push_back(exp_n);
    q_tt.push_back(tt);   q_tn.push_back(tn);
    if (int'(wa) < DEPTH) begin
      for (int l = 0; l < LANES; l++)
        if (wl[l]) model[wa][l*GRAN +: GRAN] = wd[l*GRAN +: GRAN];
    end
  endtask

  // Monitor: compares registered outputs shortly after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_t.size() > 0) begin
        check(q_tt.pop_front(), rs_data_t, q_t.pop_front());
        check(q_tn.pop_front(), rs_data_n, q_n.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_addr = '0; wr_lane_en = '0; wr_data = '0;
    rs_addr = '0; rs_en = 1'b0; ra_addr = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    model[0] = 32'h1111_1111; model[1] = 32'h2222_2222;
    model[2] = 32'h3333_3333; model[3] = 32'h4444_4444;
    exp_t = '0; exp_n = '0;
    repeat (3) @(negedge clk);
    check("R9", rs_data_t, '0);
    check("R9", rs_data_n, '0);
    ra_addr = 4'd2; #1;
    check("R7", ra_data_t, 32'h3333_3333);
    rst_n = 1'b1;

    // R7 initial rows, R3 registered read of each
    for (int i = 0; i < 6; i++)
      drive('0, '0, '0, 4'(i), 1'b1, 4'(i), "R7", "R3", "R3");

    // R1 full write row 6 with same-row reads: R4 new data, R5 old data
    drive(4'd6, 4'hF, 32'hDEAD_BEEF, 4'd6, 1'b1, 4'd6, "R2", "R4", "R5");
    drive('0, '0, '0, 4'd6, 1'b1, 4'd6, "R1", "R3", "R3");
    // R1 partial lanes 0 and 2
    drive(4'd6, 4'b0101, 32'h1122_3344, 4'd0, 1'b1, 4'd6, "R2", "R3", "R3");
    drive('0, '0, '0, 4'd6, 1'b1, 4'd6, "R1", "R3", "R3");
    // R1 empty mask changes nothing
    drive(4'd0, 4'b0000, 32'hFFFF_FFFF, 4'd0, 1'b1, 4'd0, "R1", "R3", "R3");
    drive('0, '0, '0, 4'd0, 1'b1, 4'd0, "R1", "R1", "R1");

    // R4/R5 partial-mask same-row write and read on row 7
    drive(4'd7, 4'hF, 32'hA5A5_A5A5, 4'd7, 1'b1, 4'd7, "R2", "R4", "R5");
    drive(4'd7, 4'b1000, 32'h7700_0000, 4'd7, 1'b1, 4'd7, "R2", "R4", "R5");
    drive(4'd7, 4'b0010, 32'h0000_C300, 4'd7, 1'b1, 4'd7, "R2", "R4", "R5");
    drive('0, '0, '0, 4'd7, 1'b1, 4'd7, "R1", "R3", "R3");

    // R6 hold while disabled, even across a write to the held row
    drive('0, '0, '0, 4'd3, 1'b1, 4'd3, "R2", "R3", "R3");
    drive(4'd3, 4'hF, 32'h0BAD_F00D, 4'd1, 1'b0, 4'd2, "R2", "R6", "R6");
    drive('0, '0, '0, 4'd2, 1'b0, 4'd3, "R1", "R6", "R6");
    drive('0, '0, '0, 4'd2, 1'b1, 4'd3, "R1", "R3", "R3");

    // R8 out-of-range write and reads
    drive(4'd13, 4'hF, 32'hFFFF_FFFF, 4'd13, 1'b1, 4'd13, "R8", "R8", "R8");
    drive(4'd15, 4'hF, 32'hFFFF_FFFF, 4'd14, 1'b1, 4'd14, "R8", "R8", "R8");
    drive('0, '0, '0, 4'd5, 1'b1, 4'd1, "R8", "R8", "R8");
    drive('0, '0, '0, 4'd11, 1'b1, 4'd7, "R8", "R8", "R8");
    drive('0, '0, '0, 4'd12, 1'b1, 4'd11, "R8", "R8", "R8");
    drive('0, '0, '0, 4'd0, 1'b1, 4'd0, "R7", "R8", "R8");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule